// File: doc/BRIEF.md
# Dual-Clock Byte FIFO Port Controller

This block manages a byte-wide first-in first-out store whose write side and read side run on unrelated clocks. It owns the write and read pointers, an inferred memory array, a registered tri-state byte output and two status flags: one saying there is room for more input and one saying unread data is waiting. The write side can step its pointer without storing anything, which masks input. The read side can step its pointer with the output released to high impedance, which skips stored bytes.

Each side has its own pointer reset. A read reset issued while reads are paused is remembered and applied on the next cycle in which reading resumes. One static polarity input sets the active level of all eight control and flag pins together. The flags are derived only from pointer comparisons across the clock boundary. They never gate reads or writes, so a system that ignores them will overwrite or re-read data.

Top module: `dcfifo_port_ctrl`

## Requirements
- R1: On a write-clock edge with write reset active, the write pointer returns to zero and nothing is stored, whatever write enable and input enable are.
- R2: With write enable and input enable active (and no write reset), the input byte is stored at the write pointer and the pointer advances by one.
- R3: With write enable active and input enable inactive, the write pointer advances but the addressed memory location keeps its previous byte.
- R4: With write enable inactive (and no write reset), nothing is stored and the write pointer holds.
- R5: With read enable and output enable active, the byte at the read pointer appears on the output one read-clock edge later and the read pointer advances by one.
- R6: With read enable active and output enable inactive, the read pointer advances and the output is high impedance after that edge.
- R7: With read enable inactive, the read pointer holds; the output shows the last byte read when output enable is active and is high impedance when it is inactive.
- R8: A read reset with read enable active presents the byte at address 0 (or high impedance if output enable is inactive), and the next read returns address 1.
- R9: A read reset with read enable inactive changes neither pointer nor output; it stays pending and is applied as in R8 on the next edge with read enable active.
- R10: With the polarity input high, all eight control and flag pins are active low; with it low, they are active high.
- R11: Data-available becomes active within eight read-clock cycles once the write pointer differs from the read pointer and inactive once they are equal; space-available is inactive while the write pointer is exactly one full depth ahead of the read pointer.
- R12: The flags never block: writes past full keep storing and wrap to address 0, overwriting the oldest data.
- R13: A synchronous active-high global reset clears both pointers and the pending read reset, releases the output to high impedance and shows the flags as empty with space available.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst | input | 1 | Global synchronous reset, active high, applied to both clock domains |
| polarity_sel | input | 1 | Static polarity select: 1 = controls and flags active low, 0 = active high |
| wr_clk | input | 1 | Write-side clock |
| wr_en | input | 1 | Write enable: advances the write pointer |
| in_en | input | 1 | Input enable: allows the byte to be stored |
| wr_rst | input | 1 | Write pointer reset |
| din | input | DATA_W | Input byte |
| space_ok | output | 1 | Space-available flag |
| rd_clk | input | 1 | Read-side clock |
| rd_en | input | 1 | Read enable: advances the read pointer |
| out_en | input | 1 | Output enable: drives the output instead of high impedance |
| rd_rst | input | 1 | Read pointer reset, deferred while reads are disabled |
| dout | output | DATA_W | Registered tri-state output byte |
| data_ok | output | 1 | Data-available flag |

## Verification
The bench sweeps both polarity settings over a 16-entry configuration. It runs a straight fill and drain, a fill of twenty bytes that wraps past full, and runs that mix masked and stored writes. It also covers idle write cycles with changing input, a write reset issued with both enables active, skip reads, paused reads with output enable toggled, and a read reset held while reads are paused. The masked and wrapped runs show whether storage follows the pointer or the enables. The skip and paused runs show whether the pointer and the output register move independently. The deferred reset shows that the restart waits for read enable. A bench-side pull-up makes high impedance read as all ones, and no data pattern uses that value.

// File: rtl/dcfifo_pkg.sv
package dcfifo_pkg;

  // Pointer update chosen on each edge of a side's clock.
  typedef enum logic [1:0] {
    OP_HOLD    = 2'd0,
    OP_STEP    = 2'd1,
    OP_RESTART = 2'd2
  } ptr_op_e;

  // Binary to reflected Gray code; callers truncate to their width.
  function automatic logic [31:0] to_gray(input logic [31:0] b);
    return b ^ (b >> 1);
  endfunction

endpackage

// File: rtl/dcfifo_sync.sv
module dcfifo_sync #(
  parameter int W      = 5,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    logic [W-1:0] r;
    if (g == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) r <= '0;
        else     r <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) r <= '0;
        else     r <= g_stage[g-1].r;
      end
    end
  end

  assign q = g_stage[STAGES-1].r;

endmodule

// File: rtl/dcfifo_ram.sv
module dcfifo_ram #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8
) (
  input  logic              wclk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              rclk,
  input  logic              re,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge wclk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge rclk) begin
    if (re) rdata <= mem[raddr];
  end

endmodule

// File: rtl/dcfifo_wr_side.sv
module dcfifo_wr_side
  import dcfifo_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we_a,
  input  logic              ie_a,
  input  logic              wrst_a,
  input  logic [DATA_W-1:0] din,
  input  logic [ADDR_W:0]   rgray_sync,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_waddr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic [ADDR_W:0]   wbin,
  output logic [ADDR_W:0]   wgray,
  output logic              space_a
);

  localparam int PW = ADDR_W + 1;

  ptr_op_e         op;
  logic [PW-1:0]   wbin_nxt;
  logic [PW-1:0]   wgray_nxt;
  logic [PW-1:0]   full_pat;

  always_comb begin
    if (wrst_a)    op = OP_RESTART;
    else if (we_a) op = OP_STEP;
    else           op = OP_HOLD;
    unique case (op)
      OP_RESTART: wbin_nxt = '0;
      OP_STEP:    wbin_nxt = wbin + 1'b1;
      default:    wbin_nxt = wbin;
    endcase
    wgray_nxt = PW'(to_gray(32'(wbin_nxt)));
    // Full: Gray pointers differ in the two top bits only.
    full_pat  = {~rgray_sync[PW-1:PW-2], rgray_sync[PW-3:0]};
  end

  assign mem_we    = (op == OP_STEP) && ie_a;
  assign mem_waddr = wbin[ADDR_W-1:0];
  assign mem_wdata = din;

  always_ff @(posedge clk) begin
    if (rst) begin
      wbin    <= '0;
      wgray   <= '0;
      space_a <= 1'b1;
    end else begin
      wbin    <= wbin_nxt;
      wgray   <= wgray_nxt;
      space_a <= (wgray_nxt != full_pat);
    end
  end

endmodule

// File: rtl/dcfifo_rd_side.sv
module dcfifo_rd_side
  import dcfifo_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ren_a,
  input  logic              oen_a,
  input  logic              rrst_a,
  input  logic [ADDR_W:0]   wgray_sync,
  output logic              mem_re,
  output logic [ADDR_W-1:0] mem_raddr,
  output logic [ADDR_W:0]   rbin,
  output logic [ADDR_W:0]   rgray,
  output logic              pend,
  output logic              drv,
  output logic              avail_a
);

  localparam int PW = ADDR_W + 1;

  ptr_op_e       op;
  logic [PW-1:0] rbin_nxt;
  logic [PW-1:0] rgray_nxt;

  always_comb begin
    if (ren_a && (rrst_a || pend)) op = OP_RESTART;
    else if (ren_a)                op = OP_STEP;
    else                           op = OP_HOLD;
    unique case (op)
      // Restart consumes address 0, so the next read is address 1.
      OP_RESTART: rbin_nxt = PW'(1);
      OP_STEP:    rbin_nxt = rbin + 1'b1;
      default:    rbin_nxt = rbin;
    endcase
    rgray_nxt = PW'(to_gray(32'(rbin_nxt)));
  end

  assign mem_re    = ren_a && oen_a;
  assign mem_raddr = (op == OP_RESTART) ? '0 : rbin[ADDR_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      rbin    <= '0;
      rgray   <= '0;
      pend    <= 1'b0;
      drv     <= 1'b0;
      avail_a <= 1'b0;
    end else begin
      rbin    <= rbin_nxt;
      rgray   <= rgray_nxt;
      drv     <= oen_a;
      avail_a <= (rgray_nxt != wgray_sync);
      if (ren_a)       pend <= 1'b0;
      else if (rrst_a) pend <= 1'b1;
    end
  end

endmodule

// File: rtl/dcfifo_port_ctrl.sv
module dcfifo_port_ctrl #(
  parameter int ADDR_W      = 4,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              rst,
  input  logic              polarity_sel,
  input  logic              wr_clk,
  input  logic              wr_en,
  input  logic              in_en,
  input  logic              wr_rst,
  input  logic [DATA_W-1:0] din,
  output logic              space_ok,
  input  logic              rd_clk,
  input  logic              rd_en,
  input  logic              out_en,
  input  logic              rd_rst,
  output wire  [DATA_W-1:0] dout,
  output logic              data_ok
);

  localparam int PW = ADDR_W + 1;

  // Active-level view of the controls: polarity high means active low.
  logic we_a, ie_a, wrst_a, ren_a, oen_a, rrst_a;
  assign we_a   = wr_en  ^ polarity_sel;
  assign ie_a   = in_en  ^ polarity_sel;
  assign wrst_a = wr_rst ^ polarity_sel;
  assign ren_a  = rd_en  ^ polarity_sel;
  assign oen_a  = out_en ^ polarity_sel;
  assign rrst_a = rd_rst ^ polarity_sel;

  logic              mem_we, mem_re;
  logic [ADDR_W-1:0] mem_waddr, mem_raddr;
  logic [DATA_W-1:0] mem_wdata, mem_rdata;
  logic [PW-1:0]     wbin, wgray, rbin, rgray;
  logic [PW-1:0]     wgray_rs, rgray_ws;
  logic              rd_pend, dout_drv, space_a, avail_a;

  dcfifo_wr_side #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_wr (
    .clk(wr_clk), .rst(rst), .we_a(we_a), .ie_a(ie_a), .wrst_a(wrst_a),
    .din(din), .rgray_sync(rgray_ws), .mem_we(mem_we),
    .mem_waddr(mem_waddr), .mem_wdata(mem_wdata),
    .wbin(wbin), .wgray(wgray), .space_a(space_a)
  );

  dcfifo_rd_side #(.ADDR_W(ADDR_W)) u_rd (
    .clk(rd_clk), .rst(rst), .ren_a(ren_a), .oen_a(oen_a), .rrst_a(rrst_a),
    .wgray_sync(wgray_rs), .mem_re(mem_re), .mem_raddr(mem_raddr),
    .rbin(rbin), .rgray(rgray), .pend(rd_pend), .drv(dout_drv),
    .avail_a(avail_a)
  );

  dcfifo_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_sync_w2r (
    .clk(rd_clk), .rst(rst), .d(wgray), .q(wgray_rs)
  );

  dcfifo_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_sync_r2w (
    .clk(wr_clk), .rst(rst), .d(rgray), .q(rgray_ws)
  );

  dcfifo_ram #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ram (
    .wclk(wr_clk), .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
    .rclk(rd_clk), .re(mem_re), .raddr(mem_raddr), .rdata(mem_rdata)
  );

  assign dout     = dout_drv ? mem_rdata : {DATA_W{1'bz}};
  assign space_ok = space_a ^ polarity_sel;
  assign data_ok  = avail_a ^ polarity_sel;

endmodule

// File: rtl/dcfifo_port_ctrl_chk.sv
module dcfifo_port_ctrl_chk #(
  parameter int PW = 5
) (
  input logic          wr_clk,
  input logic          rd_clk,
  input logic          rst,
  input logic          we_a,
  input logic          wrst_a,
  input logic          ren_a,
  input logic          oen_a,
  input logic          rrst_a,
  input logic [PW-1:0] wbin,
  input logic [PW-1:0] rbin,
  input logic          rd_pend,
  input logic          dout_drv
);

  assert_wptr_zero_R1: assert property (@(posedge wr_clk) disable iff (rst)
    wrst_a |=> (wbin == '0));

  assert_wptr_step_R2: assert property (@(posedge wr_clk) disable iff (rst)
    (we_a && !wrst_a) |=> (wbin == PW'($past(wbin) + 1'b1)));

  assert_wptr_hold_R4: assert property (@(posedge wr_clk) disable iff (rst)
    (!we_a && !wrst_a) |=> $stable(wbin));

  assert_skip_hiz_R6: assert property (@(posedge rd_clk) disable iff (rst)
    (ren_a && !oen_a) |=> !dout_drv);

  assert_rptr_hold_R7: assert property (@(posedge rd_clk) disable iff (rst)
    !ren_a |=> $stable(rbin));

  assert_rptr_restart_R8: assert property (@(posedge rd_clk) disable iff (rst)
    (ren_a && (rrst_a || rd_pend)) |=> (rbin == PW'(1)));

  assert_pend_hold_R9: assert property (@(posedge rd_clk) disable iff (rst)
    (!ren_a && rrst_a) |=> rd_pend);

endmodule

bind dcfifo_port_ctrl dcfifo_port_ctrl_chk #(.PW(ADDR_W + 1)) u_chk (
  .wr_clk(wr_clk), .rd_clk(rd_clk), .rst(rst),
  .we_a(we_a), .wrst_a(wrst_a), .ren_a(ren_a), .oen_a(oen_a),
  .rrst_a(rrst_a), .wbin(wbin), .rbin(rbin),
  .rd_pend(rd_pend), .dout_drv(dout_drv)
);

// File: tb/dcfifo_port_ctrl_bench.sv
module dcfifo_port_ctrl_bench;

  localparam int ADDR_W = 4;
  localparam int DEPTH  = 1 << ADDR_W;

  logic       rst = 1'b1;
  logic       polarity_sel = 1'b0;
  logic       wr_clk, rd_clk;
  logic       wr_en = 1'b0, in_en = 1'b0, wr_rst = 1'b0;
  logic [7:0] din = 8'h00;
  logic       rd_en = 1'b0, out_en = 1'b0, rd_rst = 1'b0;
  wire  [7:0] dout_w;
  logic       space_ok, data_ok;

  for (genvar b = 0; b < 8; b++) begin : g_pull
    pullup (dout_w[b]);
  end

  dcfifo_port_ctrl #(.ADDR_W(ADDR_W), .DATA_W(8)) u_dcfifo_port_ctrl (
    .rst(rst), .polarity_sel(polarity_sel),
    .wr_clk(wr_clk), .wr_en(wr_en), .in_en(in_en), .wr_rst(wr_rst),
    .din(din), .space_ok(space_ok),
    .rd_clk(rd_clk), .rd_en(rd_en), .out_en(out_en), .rd_rst(rd_rst),
    .dout(dout_w), .data_ok(data_ok)
  );

  initial begin
    wr_clk = 1'b0;
    forever #5 wr_clk = ~wr_clk;
  end

  initial begin
    rd_clk = 1'b0;
    #3;
    forever #5 rd_clk = ~rd_clk;
  end

  int   n_run  = 0;
  int   n_fail = 0;
  bit   done   = 1'b0;
  bit   pol    = 1'b0;

  logic [7:0] m_mem [DEPTH];
  int         m_wp, m_rp;
  bit         m_pend;
  logic [7:0] m_last;

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s pol=%0d actual=%02h expected=%02h", tag, pol, act, exp);
    end
  endtask

  task automatic wr(input bit we, input bit ie, input bit rs, input logic [7:0] d);
    @(negedge wr_clk);
    wr_en = we ^ pol; in_en = ie ^ pol; wr_rst = rs ^ pol; din = d;
    @(posedge wr_clk); #1;
    if (rs) m_wp = 0;
    else if (we) begin
      if (ie) m_mem[m_wp] = d;
      m_wp = (m_wp + 1) % DEPTH;
    end
  endtask

  task automatic wr_idle();
    @(negedge wr_clk);
    wr_en = pol; in_en = pol; wr_rst = pol;
  endtask

  task automatic rd(input bit re, input bit oe, input bit rs, input string tag);
    @(negedge rd_clk);
    rd_en = re ^ pol; out_en = oe ^ pol; rd_rst = rs ^ pol;
    @(posedge rd_clk); #2;
    if (re && (rs || m_pend)) begin
      if (oe) m_last = m_mem[0];
      m_rp = 1; m_pend = 1'b0;
    end else if (re) begin
      if (oe) m_last = m_mem[m_rp];
      m_rp = (m_rp + 1) % DEPTH;
    end else if (rs) m_pend = 1'b1;
    chk(tag, dout_w, oe ? m_last : 8'hFF);
  endtask

  task automatic rd_idle();
    @(negedge rd_clk);
    rd_en = pol; out_en = pol; rd_rst = pol;
  endtask

  task automatic chk_flags(input bit e_data, input bit e_space, input string tag);
    repeat (8) @(posedge rd_clk);
    #2;
    chk({tag, " data_ok"},  {7'd0, data_ok},  {7'd0, e_data ^ pol});
    chk({tag, " space_ok"}, {7'd0, space_ok}, {7'd0, e_space ^ pol});
  endtask

  task automatic global_reset(input bit p);
    pol = p;
    @(negedge wr_clk);
    rst = 1'b1; polarity_sel = p;
    wr_en = p; in_en = p; wr_rst = p; rd_en = p; out_en = p; rd_rst = p;
    repeat (4) @(posedge wr_clk);
    @(negedge wr_clk);
    rst = 1'b0;
    m_wp = 0; m_rp = 0; m_pend = 1'b0; m_last = 8'hFF;
    @(posedge rd_clk); #2;
  endtask

  initial begin
    for (int p = 0; p < 2; p++) begin
      global_reset(p[0]);
      // R13 / R10: idle state after reset, in this polarity
      chk("R13 hiz", dout_w, 8'hFF);
      chk("R13 R10 data_ok", {7'd0, data_ok},  {7'd0, pol});
      chk("R13 R10 space_ok", {7'd0, space_ok}, {7'd0, ~pol});

      // R2 / R11: fill exactly one depth
      for (int i = 0; i < DEPTH; i++) wr(1, 1, 0, 8'((i * 7 + 3 + p * 64) & 8'h7F));
      wr_idle();
      chk_flags(1, 0, "R11 full");

      // R12: keep writing past full; wraps onto addresses 0..3
      for (int i = 0; i < 4; i++) wr(1, 1, 0, 8'(8'h60 + i));
      wr_idle();
      rd(1, 1, 1, "R8 restart");
      for (int i = 0; i < DEPTH + 3; i++) rd(1, 1, 0, "R12 R5 drain");
      rd_idle();
      chk_flags(0, 1, "R11 empty");

      // R3: masked writes keep old bytes, then R2 stores
      wr(1, 1, 1, 8'h00);
      for (int i = 0; i < 4; i++) wr(1, 0, 0, 8'(8'hA0 + i));
      for (int i = 4; i < 8; i++) wr(1, 1, 0, 8'(8'h50 + i));
      wr_idle();
      rd(1, 1, 1, "R3 restart");
      for (int i = 1; i < 8; i++) rd(1, 1, 0, "R3 R2 readback");

      // R4: idle write cycles neither store nor move the pointer
      wr(1, 1, 1, 8'h00);
      wr(1, 1, 0, 8'h11);
      for (int i = 0; i < 3; i++) wr(0, 1, 0, 8'(8'h22 + i));
      wr(0, 0, 0, 8'h2A);
      wr(1, 1, 0, 8'h33);
      wr_idle();
      rd(1, 1, 1, "R4 addr0");
      rd(1, 1, 0, "R4 addr1");
      rd(1, 1, 0, "R4 addr2");

      // R1: write reset with both enables active stores nothing
      wr(1, 1, 1, 8'hEE);
      wr_idle();
      rd(1, 1, 1, "R1 addr0");

      // R6: skip reads release the output, pointer still moves
      rd(1, 0, 1, "R6 restart hiz");
      rd(1, 0, 0, "R6 skip");
      rd(1, 0, 0, "R6 skip");
      rd(1, 1, 0, "R6 after skip");

      // R7: paused reads hold data or release the output
      for (int i = 0; i < 3; i++) rd(0, 1, 0, "R7 hold");
      rd(0, 0, 0, "R7 hiz");
      rd(0, 1, 0, "R7 hold again");

      // R9: read reset during a pause is deferred
      rd(0, 1, 1, "R9 pending");
      rd(0, 1, 0, "R9 pending hold");
      rd(0, 1, 0, "R9 pending hold");
      rd(1, 1, 0, "R9 applied");
      rd(1, 1, 0, "R9 next");
      rd_idle();
    end
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #1500000;
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog R13 actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule